// File: doc/BRIEF.md
# Reverse and Leading-Zero Execution Unit

This block executes the reverse-family and count-leading-zeros operations of the 32-bit instruction space whose first halfword has the top byte 0xFA. Each cycle it takes a request strobe, the two instruction halfwords and one source operand. One clock later it answers a claimed request with either a result strobe and a new result word, or a fault strobe that reports an illegal instruction. Register file access, fetch and exception entry belong to the surrounding core.

Decoding looks at two fields: the group field in bits [7:4] of the first halfword and the selector field in bits [7:4] of the second halfword. If only the selector were checked, the extend-and-add, saturating-arithmetic and byte-select encodings that share this space would run as reverse operations. They fault instead. Requests whose selector is zero belong to the register-controlled shift unit, and this block does not answer them. The count-leading-zeros logic can be built as a loop-style priority scan or as a shift-and-test tree. A parameter picks the variant.

Top module: `rev_clz_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, `res_valid` and `fault` are 0 and `res_data` is 0.
- R2: A request is claimed only when `req_valid` is 1, `instr_hi[15:8]` is 0xFA and `instr_lo[7:4]` is nonzero. An unclaimed request produces neither strobe and leaves `res_data` unchanged. This covers a zero selector, a different top byte and a dropped `req_valid`.
- R3: Group `instr_hi[7:4]` = 0x9 with selector `instr_lo[7:4]` = 0x8 returns the operand with its four bytes in reverse order, so 0x12345678 gives 0x78563412.
- R4: Group 0x9 with selector 0x9 swaps the two bytes inside each 16-bit half on its own, so 0x12345678 gives 0x34127856.
- R5: Group 0x9 with selector 0xA returns the operand with its 32 bits in reverse order.
- R6: Group 0x9 with selector 0xB swaps the two bytes of the low halfword and sign-extends bit 15 of the swapped value to 32 bits, so 0x123480FF gives 0xFFFFFF80.
- R7: Group 0xB with selector 0x8 returns the number of leading zero bits of the operand, and 32 for an operand of zero.
- R8: Every other claimed encoding faults. This covers any group other than 0x9 or 0xB (0, 1, 2, 3, 8 and A included), group 0xB with a selector other than 0x8, and group 0x9 with a selector outside 0x8 to 0xB.
- R9: For each claimed request exactly one of `res_valid` and `fault` is 1. When `fault` is 1, `res_data` keeps its previous value.
- R10: Outputs appear on the clock edge after the request. Each strobe stays high for one cycle only, unless another claimed request follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe for the current cycle |
| instr_hi | input | 16 | First instruction halfword |
| instr_lo | input | 16 | Second instruction halfword |
| src_data | input | DATA_W | Source operand |
| res_valid | output | 1 | Result strobe, one cycle after a legal request |
| res_data | output | DATA_W | Result word, held between results |
| fault | output | 1 | Illegal-instruction strobe, one cycle after a rejected request |

## Verification
The fault and the result strobe answer the same request stream, so a wrong decode could raise both at once, or could let a rejected request overwrite the result word. The bench drives legal and illegal encodings back to back on consecutive cycles. It includes every rejected group next to a reverse request and unclaimed gaps in between. A behavioural model predicts both strobes and the held result word for every cycle. A cycle matches only if one strobe or neither is high, as the model predicts, and the result word equals the last legal result.

// File: rtl/rev_clz_pkg.sv
package rev_clz_pkg;

   typedef enum logic [2:0] {
      OPK_IDLE,
      OPK_BREV,
      OPK_HPREV,
      OPK_BITREV,
      OPK_SHREV,
      OPK_LZC,
      OPK_ILLEGAL
   } opk_t;

   localparam logic [7:0] SPACE_TAG   = 8'hFA;
   localparam logic [3:0] GRP_REVERSE = 4'h9;
   localparam logic [3:0] GRP_COUNT   = 4'hB;
   localparam logic [3:0] SEL_BYTE    = 4'h8;
   localparam logic [3:0] SEL_HALF    = 4'h9;
   localparam logic [3:0] SEL_BIT     = 4'hA;
   localparam logic [3:0] SEL_SHALF   = 4'hB;

endpackage

// File: rtl/rev_clz_decode.sv
module rev_clz_decode
   import rev_clz_pkg::*;
(
   input  logic        req_valid,
   input  logic [15:0] instr_hi,
   input  logic [15:0] instr_lo,
   output opk_t        kind
);

   logic [3:0] grp;
   logic [3:0] sel;
   logic       claimed;
   logic       unused_fields;

   assign grp     = instr_hi[7:4];
   assign sel     = instr_lo[7:4];
   assign claimed = req_valid && (instr_hi[15:8] == SPACE_TAG) && (sel != 4'h0);
   assign unused_fields = ^{instr_hi[3:0], instr_lo[15:8], instr_lo[3:0]};

   always_comb begin
      kind = OPK_IDLE;
      if (claimed) begin
         if (grp == GRP_COUNT && sel == SEL_BYTE) begin
            kind = OPK_LZC;
         end else if (grp == GRP_REVERSE) begin
            case (sel)
               SEL_BYTE:  kind = OPK_BREV;
               SEL_HALF:  kind = OPK_HPREV;
               SEL_BIT:   kind = OPK_BITREV;
               SEL_SHALF: kind = OPK_SHREV;
               default:   kind = OPK_ILLEGAL;
            endcase
         end else begin
            kind = OPK_ILLEGAL;
         end
      end
   end

endmodule

// File: rtl/rev_clz_permute.sv
module rev_clz_permute #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W-1:0] byte_rev,
   output logic [DATA_W-1:0] half_rev,
   output logic [DATA_W-1:0] bit_rev,
   output logic [DATA_W-1:0] shalf_rev
);

   localparam int N_BYTES = DATA_W / 8;
   localparam int N_HALVES = DATA_W / 16;
   localparam int EXT_W = DATA_W - 16;

   if ((DATA_W % 16) != 0 || DATA_W < 32) begin : g_bad_width
      $error("rev_clz_permute: DATA_W must be a multiple of 16 and at least 32");
   end

   for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
      assign byte_rev[8*b +: 8] = src[8*(N_BYTES-1-b) +: 8];
   end

   for (genvar h = 0; h < N_HALVES; h++) begin : g_half
      assign half_rev[16*h +: 8]     = src[16*h+8 +: 8];
      assign half_rev[16*h+8 +: 8]   = src[16*h +: 8];
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign bit_rev[i] = src[DATA_W-1-i];
   end

   logic [15:0] low_swapped;
   assign low_swapped = {src[7:0], src[15:8]};
   assign shalf_rev   = {{EXT_W{low_swapped[15]}}, low_swapped};

endmodule

// File: rtl/rev_clz_lzc.sv
module rev_clz_lzc #(
   parameter int DATA_W = 32,
   parameter bit TREE   = 1'b1,
   localparam int CNT_W = $clog2(DATA_W) + 1
) (
   input  logic [DATA_W-1:0] src,
   output logic [CNT_W-1:0]  count
);

   localparam int LVL = $clog2(DATA_W);

   if ((1 << LVL) != DATA_W) begin : g_bad_width
      $error("rev_clz_lzc: DATA_W must be a power of two");
   end

   if (TREE) begin : g_tree
      logic [DATA_W-1:0] stg_v [0:LVL];
      logic [CNT_W-1:0]  stg_c [0:LVL];

      assign stg_v[0] = src;
      assign stg_c[0] = '0;

      for (genvar g = 0; g < LVL; g++) begin : g_lvl
         localparam int SH = DATA_W >> (g + 1);
         logic top_zero;
         assign top_zero   = (stg_v[g][DATA_W-1 -: SH] == '0);
         assign stg_v[g+1] = top_zero ? (stg_v[g] << SH) : stg_v[g];
         assign stg_c[g+1] = stg_c[g] + (top_zero ? CNT_W'(SH) : CNT_W'(0));
      end

      logic unused_tail;
      assign unused_tail = ^stg_v[LVL][DATA_W-2:0];
      assign count = stg_c[LVL] + (stg_v[LVL][DATA_W-1] ? CNT_W'(0) : CNT_W'(1));
   end else begin : g_scan
      always_comb begin
         count = CNT_W'(DATA_W);
         for (int i = 0; i < DATA_W; i++) begin
            if (src[i]) count = CNT_W'(DATA_W - 1 - i);
         end
      end
   end

endmodule

// File: rtl/rev_clz_unit.sv
module rev_clz_unit
   import rev_clz_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit LZC_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [15:0]       instr_hi,
   input  logic [15:0]       instr_lo,
   input  logic [DATA_W-1:0] src_data,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic              fault
);

   localparam int CNT_W = $clog2(DATA_W) + 1;

   opk_t              kind;
   logic [DATA_W-1:0] byte_rev;
   logic [DATA_W-1:0] half_rev;
   logic [DATA_W-1:0] bit_rev;
   logic [DATA_W-1:0] shalf_rev;
   logic [CNT_W-1:0]  lz_count;
   logic [DATA_W-1:0] next_data;
   logic              exec;

   rev_clz_decode u_decode (
      .req_valid (req_valid),
      .instr_hi  (instr_hi),
      .instr_lo  (instr_lo),
      .kind      (kind)
   );

   rev_clz_permute #(.DATA_W(DATA_W)) u_permute (
      .src       (src_data),
      .byte_rev  (byte_rev),
      .half_rev  (half_rev),
      .bit_rev   (bit_rev),
      .shalf_rev (shalf_rev)
   );

   rev_clz_lzc #(.DATA_W(DATA_W), .TREE(LZC_TREE)) u_lzc (
      .src   (src_data),
      .count (lz_count)
   );

   assign exec = (kind != OPK_IDLE) && (kind != OPK_ILLEGAL);

   always_comb begin
      case (kind)
         OPK_BREV:   next_data = byte_rev;
         OPK_HPREV:  next_data = half_rev;
         OPK_BITREV: next_data = bit_rev;
         OPK_SHREV:  next_data = shalf_rev;
         default:    next_data = {{(DATA_W-CNT_W){1'b0}}, lz_count};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         fault     <= 1'b0;
         res_data  <= '0;
      end else begin
         res_valid <= exec;
         fault     <= (kind == OPK_ILLEGAL);
         if (exec) res_data <= next_data;
      end
   end

endmodule

// File: rtl/rev_clz_unit_chk.sv
module rev_clz_unit_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [15:0]       instr_hi,
   input logic [15:0]       instr_lo,
   input logic [DATA_W-1:0] src_data,
   input logic              res_valid,
   input logic [DATA_W-1:0] res_data,
   input logic              fault
);

   logic [3:0] grp;
   logic [3:0] sel;
   logic       claimed;
   logic       unused_bits;

   assign grp     = instr_hi[7:4];
   assign sel     = instr_lo[7:4];
   assign claimed = req_valid && (instr_hi[15:8] == 8'hFA) && (sel != 4'h0);
   assign unused_bits = ^{instr_hi[3:0], instr_lo[15:8], instr_lo[3:0]};

   assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && fault));

   assert_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
      claimed |=> (res_valid != fault));

   assert_hold_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $stable(res_data));

   assert_unclaimed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !claimed |=> (!res_valid && !fault));

   assert_bad_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (claimed && grp != 4'h9 && grp != 4'hB) |=> fault);

   assert_lzc_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (claimed && grp == 4'hB && sel == 4'h8 && src_data == '0)
      |=> (res_valid && res_data == DATA_W));

   assert_shalf_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (claimed && grp == 4'h9 && sel == 4'hB)
      |=> (res_valid
           && res_data[15:0] == {$past(src_data[7:0]), $past(src_data[15:8])}
           && res_data[DATA_W-1:16] == {(DATA_W-16){res_data[15]}}));

endmodule

bind rev_clz_unit rev_clz_unit_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .instr_hi  (instr_hi),
   .instr_lo  (instr_lo),
   .src_data  (src_data),
   .res_valid (res_valid),
   .res_data  (res_data),
   .fault     (fault)
);

// File: tb/rev_clz_unit_bench.sv
`timescale 1ns/1ps
module rev_clz_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] instr_hi = '0;
   logic [15:0] instr_lo = '0;
   logic [31:0] src_data = '0;
   logic        res_valid;
   logic [31:0] res_data;
   logic        fault;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   logic        exp_v = 1'b0;
   logic        exp_f = 1'b0;
   logic [31:0] exp_d = '0;
   string       cur_tag = "R1 reset";

   always #5 clk = ~clk;

   rev_clz_unit u_rev_clz_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .instr_hi  (instr_hi),
      .instr_lo  (instr_lo),
      .src_data  (src_data),
      .res_valid (res_valid),
      .res_data  (res_data),
      .fault     (fault)
   );

   function automatic logic [31:0] m_rbit(input logic [31:0] x);
      logic [31:0] r = '0;
      for (int i = 0; i < 32; i++) r[31-i] = x[i];
      return r;
   endfunction

   function automatic logic [31:0] m_clz(input logic [31:0] x);
      int n = 0;
      while (n < 32 && x[31-n] == 1'b0) n++;
      return 32'(n);
   endfunction

   task automatic compare();
      compared++;
      if (res_valid !== exp_v || fault !== exp_f || res_data !== exp_d) begin
         mismatched++;
         $display("FAIL %s: actual v=%0b f=%0b d=%h expected v=%0b f=%0b d=%h",
                  cur_tag, res_valid, fault, res_data, exp_v, exp_f, exp_d);
      end
   endtask

   task automatic model(input logic v, input logic [15:0] hi, input logic [15:0] lo,
                        input logic [31:0] s);
      logic [3:0] g = hi[7:4];
      logic [3:0] k = lo[7:4];
      exp_v = 1'b0;
      exp_f = 1'b0;
      if (v && hi[15:8] == 8'hFA && k != 4'h0) begin
         if (g == 4'hB && k == 4'h8) begin
            exp_v = 1'b1; exp_d = m_clz(s);
         end else if (g == 4'h9 && k == 4'h8) begin
            exp_v = 1'b1; exp_d = {s[7:0], s[15:8], s[23:16], s[31:24]};
         end else if (g == 4'h9 && k == 4'h9) begin
            exp_v = 1'b1; exp_d = {s[23:16], s[31:24], s[7:0], s[15:8]};
         end else if (g == 4'h9 && k == 4'hA) begin
            exp_v = 1'b1; exp_d = m_rbit(s);
         end else if (g == 4'h9 && k == 4'hB) begin
            exp_v = 1'b1; exp_d = {{16{s[7]}}, s[7:0], s[15:8]};
         end else begin
            exp_f = 1'b1;
         end
      end
   endtask

   task automatic step(input logic v, input logic [15:0] hi, input logic [15:0] lo,
                       input logic [31:0] s, input string tag);
      @(negedge clk);
      compare();
      req_valid = v; instr_hi = hi; instr_lo = lo; src_data = s;
      model(v, hi, lo, s);
      cur_tag = tag;
   endtask

   initial begin
      repeat (3) begin
         @(negedge clk);
         compare();
      end
      rst_n = 1'b1;
      cur_tag = "R1 first cycle after reset";

      step(1, 16'hFA91, 16'hF081, 32'h12345678, "R3 byte reverse");
      step(1, 16'hFA91, 16'hF091, 32'h12345678, "R4 halfword-pair reverse");
      step(1, 16'hFA91, 16'hF0A1, 32'h00000001, "R5 bit reverse lsb");
      step(1, 16'hFA91, 16'hF0A1, 32'hF00D1234, "R5 bit reverse pattern");
      step(1, 16'hFA91, 16'hF0B1, 32'h123480FF, "R6 signed halfword negative");
      step(1, 16'hFA91, 16'hF0B1, 32'hFFFF3412, "R6 signed halfword positive");
      step(1, 16'hFAB1, 16'hF081, 32'h00000000, "R7 clz of zero");
      step(1, 16'hFAB1, 16'hF081, 32'h80000000, "R7 clz msb set");
      step(1, 16'hFAB1, 16'hF081, 32'h00000001, "R7 clz lsb only");
      step(1, 16'hFAB1, 16'hF081, 32'h00010000, "R7 clz mid");
      step(1, 16'hFA01, 16'hF082, 32'h11111111, "R8 group 0 faults, R9 data held");
      step(1, 16'hFA11, 16'hF082, 32'h22222222, "R8 group 1 faults");
      step(1, 16'hFA91, 16'hF081, 32'hAABBCCDD, "R9 legal between faults");
      step(1, 16'hFA2F, 16'hF081, 32'h33333333, "R8 group 2 faults");
      step(1, 16'hFA3F, 16'hF081, 32'h44444444, "R8 group 3 faults");
      step(1, 16'hFA82, 16'hF0A1, 32'h55555555, "R8 group 8 faults");
      step(1, 16'hFAA1, 16'hF082, 32'h66666666, "R8 group A faults");
      step(1, 16'hFA41, 16'hF081, 32'h77777777, "R8 group 4 faults");
      step(1, 16'hFAF1, 16'hF081, 32'h88888888, "R8 group F faults");
      step(1, 16'hFAB1, 16'hF091, 32'h99999999, "R8 group B selector 9 faults");
      step(1, 16'hFA91, 16'hF0C1, 32'hAAAAAAAA, "R8 group 9 selector C faults");
      step(1, 16'hFA91, 16'hF011, 32'hBBBBBBBB, "R8 group 9 selector 1 faults");
      step(1, 16'hFA91, 16'hF001, 32'hCCCCCCCC, "R2 zero selector unclaimed");
      step(1, 16'hFB91, 16'hF081, 32'hDDDDDDDD, "R2 other top byte unclaimed");
      step(0, 16'hFA91, 16'hF081, 32'hEEEEEEEE, "R2 no request strobe");
      step(0, 16'h0000, 16'h0000, 32'h0, "R10 strobes drop when idle");
      step(1, 16'hFA91, 16'hF081, 32'h01020304, "R10 back-to-back first");
      step(1, 16'hFA91, 16'hF091, 32'h01020304, "R10 back-to-back second");
      step(0, 16'h0000, 16'h0000, 32'h0, "R10 idle after burst");

      for (int n = 0; n < 3000; n++) begin
         logic [15:0] hi;
         logic [15:0] lo;
         hi = {(($urandom % 8) == 0) ? 8'($urandom) : 8'hFA, 4'($urandom), 4'($urandom)};
         if (($urandom % 2) == 0) hi[7:4] = (($urandom % 2) == 0) ? 4'h9 : 4'hB;
         lo = 16'($urandom);
         if (($urandom % 2) == 0) lo[7:4] = 4'h8 + 4'($urandom % 4);
         step(($urandom % 8) != 0, hi, lo, $urandom, "R9 random mix R3 R8");
      end
      step(0, 16'h0000, 16'h0000, 32'h0, "R10 final flush");
      @(negedge clk);
      compare();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL R10 watchdog expired: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule